// File: doc/BRIEF.md
# Programmable delay counter with buffered reload

The block is a triggered 16-bit up-counter for timing a delay after an event. A trigger selector picks one of fifteen hardware trigger lines or a software trigger pulse. The selected trigger starts the count from zero. The count advances once per prescaled period and wraps, or stops, at a programmable modulus. A delay event flag is raised when the count reaches a programmable delay value, and that flag can drive an interrupt line. Other logic may use the current count as a time base.

The modulus, the delay value and the prescale settings are written into a shadow copy. The active copy, which the counter uses, changes only after a load-request bit has been set and the selected load condition has occurred. This lets a running sequence be reprogrammed without tearing. Clearing the enable input stops the counter, holds it at zero and drops any pending load request.

Top module: `dly_timer`

## Requirements
- R1: After reset, count_o is 0 and ldok_o, flag_o and irq_o are all 0.
- R2: trig_sel_i codes 0 to 14 select hw_trig_i bit 0 to 14, and code 15 selects sw_trig_i. A pulse on a trigger line that is not selected is ignored. A selected trigger at a clock edge, with en_i high, sets count_o to 0 and starts counting.
- R3: While running, the count advances by one every R cycles. R is D·M, where D = 2^cfg_pre (pre codes 0 to 7 give 1 to 128) and M is 1, 10, 20 or 40 for mult codes 0, 1, 2 and 3. Both are taken from the active configuration, and the prescale phase restarts on every trigger.
- R4: With cont_i high, the step after the count equals the active modulus returns the count to 0, and counting goes on.
- R5: With cont_i low, the counter stops when the count equals the active modulus and holds that value.
- R6: A selected trigger that arrives while the counter is running restarts the count from 0.
- R7: flag_o sets in the first prescale cycle in which the running count equals the active delay value. It then stays set until a flag_clr_i pulse, and a new delay event wins over a clear in the same cycle.
- R8: irq_o is high exactly when flag_o and dly_ie_i are both high.
- R9: cfg_we_i writes only the shadow copy. The shadow copy moves to the active copy at an edge where ldok_o is high, en_i is high and the condition chosen by ld_mode_i holds: 0 means always (the edge after ldok is set), 1 means a modulus wrap, 2 means a selected trigger, and 3 means either a wrap or a trigger.
- R10: ldok_set_i sets ldok_o. ldok_o clears itself on the transfer edge, clears whenever en_i is low, and a set request made while en_i is low is ignored.
- R11: While en_i is low, count_o is held at 0 and the counter does not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| cont_i | input | 1 | Continuous mode when high, one-shot when low |
| trig_sel_i | input | 4 | Trigger source select, 15 is software |
| hw_trig_i | input | 15 | Hardware trigger lines |
| sw_trig_i | input | 1 | Software trigger pulse |
| cfg_we_i | input | 1 | Shadow configuration write strobe |
| cfg_mod_i | input | 16 | Shadow modulus value |
| cfg_dly_i | input | 16 | Shadow delay event value |
| cfg_pre_i | input | 3 | Shadow power-of-two prescale code |
| cfg_mult_i | input | 2 | Shadow prescale multiplier code |
| ld_mode_i | input | 2 | Load condition select |
| ldok_set_i | input | 1 | Request transfer of the shadow copy |
| dly_ie_i | input | 1 | Delay interrupt enable |
| flag_clr_i | input | 1 | Clear the delay event flag |
| count_o | output | 16 | Current count |
| ldok_o | output | 1 | Load request pending |
| flag_o | output | 1 | Delay event flag |
| irq_o | output | 1 | Delay interrupt |

## Verification
Directed sequences use the fastest prescale setting with small moduli. They separate a continuous wrap from a one-shot hold, a restart from a wrap, and a held shadow value from a transferred one. A slow setting with divide-by-2 and a times-10 multiplier checks the exact cycle on which the count steps. Random traffic then mixes short moduli, several prescale ratios, all four load modes, both trigger paths, stray pulses on lines that are not selected, enable drops and flag clears. A cycle-level reference model checks every output in every cycle. This is what exposes errors in load timing and in priority between concurrent events, which directed cases miss.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 3;
  localparam int MULT_W = 2;
  localparam int PSC_W  = (1 << PRE_W) + 6;

  typedef enum logic [1:0] {
    LD_NOW    = 2'd0,
    LD_WRAP   = 2'd1,
    LD_TRIG   = 2'd2,
    LD_EITHER = 2'd3
  } ld_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0]  modv;
    logic [CNT_W-1:0]  dlyv;
    logic [PRE_W-1:0]  pre;
    logic [MULT_W-1:0] mult;
  } tcfg_t;

  localparam tcfg_t CFG_RST = '{modv: '1, dlyv: '1, pre: '0, mult: '0};
endpackage

// File: rtl/dly_trig_sel.sv
module dly_trig_sel #(
  parameter int N_HW  = 15,
  parameter int SEL_W = $clog2(N_HW + 1)
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_HW-1:0]  hw_i,
  input  logic             sw_i,
  output logic             ev_o
);
  logic [N_HW:0] src;
  logic          pick;

  assign src = {sw_i, hw_i};

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i <= N_HW; i++) begin
      if (sel_i == SEL_W'(i)) pick = src[i];
    end
  end

  assign ev_o = en_i & pick;
endmodule

// File: rtl/dly_prescaler.sv
module dly_prescaler
  import dly_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              tick_o,
  output logic              phase0_o
);
  logic [5:0]       mf;
  logic [PSC_W-1:0] ratio;
  logic [PSC_W-1:0] psc_q;

  always_comb begin
    unique case (mult_i)
      2'd0:    mf = 6'd1;
      2'd1:    mf = 6'd10;
      2'd2:    mf = 6'd20;
      default: mf = 6'd40;
    endcase
  end

  assign ratio    = PSC_W'(mf) << pre_i;
  assign tick_o   = run_i & (psc_q == ratio - PSC_W'(1));
  assign phase0_o = (psc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         psc_q <= '0;
    else if (clr_i || !run_i || tick_o) psc_q <= '0;
    else                                 psc_q <= psc_q + PSC_W'(1);
  end
endmodule

// File: rtl/dly_reload.sv
module dly_reload
  import dly_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       we_i,
  input  tcfg_t      wcfg_i,
  input  logic       ldok_set_i,
  input  ld_mode_e   mode_i,
  input  logic       wrap_i,
  input  logic       trig_i,
  output tcfg_t      act_o,
  output logic       ldok_o
);
  tcfg_t sh_q, act_q;
  logic  ldok_q, cond, xfer;

  always_comb begin
    unique case (mode_i)
      LD_NOW:  cond = 1'b1;
      LD_WRAP: cond = wrap_i;
      LD_TRIG: cond = trig_i;
      default: cond = wrap_i | trig_i;
    endcase
  end

  assign xfer = ldok_q & en_i & cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= CFG_RST;
      act_q  <= CFG_RST;
      ldok_q <= 1'b0;
    end else begin
      if (we_i) sh_q <= wcfg_i;
      if (xfer) act_q <= sh_q;
      if (!en_i)           ldok_q <= 1'b0;
      else if (ldok_set_i) ldok_q <= 1'b1;
      else if (xfer)       ldok_q <= 1'b0;
    end
  end

  assign act_o  = act_q;
  assign ldok_o = ldok_q;
endmodule

// File: rtl/dly_timer.sv
module dly_timer
  import dly_pkg::*;
#(
  parameter int N_HW  = 15,
  parameter int SEL_W = $clog2(N_HW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_i,
  input  logic [SEL_W-1:0]  trig_sel_i,
  input  logic [N_HW-1:0]   hw_trig_i,
  input  logic              sw_trig_i,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_mod_i,
  input  logic [CNT_W-1:0]  cfg_dly_i,
  input  logic [PRE_W-1:0]  cfg_pre_i,
  input  logic [MULT_W-1:0] cfg_mult_i,
  input  logic [1:0]        ld_mode_i,
  input  logic              ldok_set_i,
  input  logic              dly_ie_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ldok_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic             trig_ev, tick, phase0, wrap, hit, at_mod;
  logic             run_q, flag_q;
  logic [CNT_W-1:0] cnt_q;
  tcfg_t            act_cfg, wcfg;

  assign wcfg = '{modv: cfg_mod_i, dlyv: cfg_dly_i, pre: cfg_pre_i, mult: cfg_mult_i};

  dly_trig_sel #(.N_HW(N_HW), .SEL_W(SEL_W)) i_sel (
    .en_i  (en_i),
    .sel_i (trig_sel_i),
    .hw_i  (hw_trig_i),
    .sw_i  (sw_trig_i),
    .ev_o  (trig_ev)
  );

  dly_prescaler i_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (trig_ev | ~en_i),
    .run_i    (run_q),
    .pre_i    (act_cfg.pre),
    .mult_i   (act_cfg.mult),
    .tick_o   (tick),
    .phase0_o (phase0)
  );

  dly_reload i_rld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .we_i       (cfg_we_i),
    .wcfg_i     (wcfg),
    .ldok_set_i (ldok_set_i),
    .mode_i     (ld_mode_e'(ld_mode_i)),
    .wrap_i     (wrap),
    .trig_i     (trig_ev),
    .act_o      (act_cfg),
    .ldok_o     (ldok_o)
  );

  assign at_mod = (cnt_q == act_cfg.modv);
  assign wrap   = en_i & ~trig_ev & tick & at_mod;
  assign hit    = en_i & run_q & phase0 & (cnt_q == act_cfg.dlyv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (trig_ev) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (tick) begin
      if (!at_mod)     cnt_q <= cnt_q + CNT_W'(1);
      else if (cont_i) cnt_q <= '0;
      else             run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & dly_ie_i;
endmodule

// File: rtl/dly_timer_chk.sv
module dly_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        flag_clr_i,
  input logic        trig_ev,
  input logic [15:0] count_o,
  input logic        ldok_o,
  input logic        flag_o,
  input logic        irq_o
);
  p_idle_when_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_o == 16'd0));

  p_step_by_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 16'd1 || count_o == 16'd0));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_ev |=> (count_o == 16'd0));

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  p_ldok_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ldok_o);
endmodule

bind dly_timer dly_timer_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .flag_clr_i (flag_clr_i),
  .trig_ev    (trig_ev),
  .count_o    (count_o),
  .ldok_o     (ldok_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/test_dly_timer.sv
`timescale 1ns/1ps
module test_dly_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, cont = 1'b1, sw = 1'b0, we = 1'b0, ldset = 1'b0, ie = 1'b0, fclr = 1'b0;
  logic [3:0]  sel = 4'd15;
  logic [14:0] hw = '0;
  logic [15:0] wmod = '0, wdly = '0;
  logic [2:0]  wpre = '0;
  logic [1:0]  wmult = '0, mode = '0;
  logic [15:0] count;
  logic        ldok, flag, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dly_timer i_dly_timer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cont_i(cont), .trig_sel_i(sel),
    .hw_trig_i(hw), .sw_trig_i(sw), .cfg_we_i(we), .cfg_mod_i(wmod), .cfg_dly_i(wdly),
    .cfg_pre_i(wpre), .cfg_mult_i(wmult), .ld_mode_i(mode), .ldok_set_i(ldset),
    .dly_ie_i(ie), .flag_clr_i(fclr), .count_o(count), .ldok_o(ldok), .flag_o(flag), .irq_o(irq)
  );

  function automatic int ratio_f(logic [2:0] p, logic [1:0] m);
    int f;
    case (m)
      2'd0: f = 1;
      2'd1: f = 10;
      2'd2: f = 20;
      default: f = 40;
    endcase
    return f << p;
  endfunction

  // reference model built from the requirements
  logic [15:0] m_cnt, s_mod, s_dly, a_mod, a_dly;
  logic [2:0]  s_pre, a_pre;
  logic [1:0]  s_mult, a_mult;
  logic        m_run, m_ldok, m_flag;
  int          m_psc;
  bit          m_ev, m_tick, m_wrap, m_hit, m_cond, m_xfer;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_psc <= 0; m_run <= 0; m_ldok <= 0; m_flag <= 0;
      s_mod <= 16'hFFFF; s_dly <= 16'hFFFF; s_pre <= '0; s_mult <= '0;
      a_mod <= 16'hFFFF; a_dly <= 16'hFFFF; a_pre <= '0; a_mult <= '0;
    end else begin
      m_ev   = en && ((sel == 4'd15) ? sw : hw[sel]);
      m_tick = m_run && (m_psc == ratio_f(a_pre, a_mult) - 1);
      m_wrap = en && !m_ev && m_tick && (m_cnt == a_mod);
      m_hit  = en && m_run && (m_psc == 0) && (m_cnt == a_dly);
      case (mode)
        2'd0: m_cond = 1;
        2'd1: m_cond = m_wrap;
        2'd2: m_cond = m_ev;
        default: m_cond = m_wrap || m_ev;
      endcase
      m_xfer = m_ldok && en && m_cond;
      if (we) begin s_mod <= wmod; s_dly <= wdly; s_pre <= wpre; s_mult <= wmult; end
      if (m_xfer) begin a_mod <= s_mod; a_dly <= s_dly; a_pre <= s_pre; a_mult <= s_mult; end
      if (!en) m_ldok <= 0; else if (ldset) m_ldok <= 1; else if (m_xfer) m_ldok <= 0;
      if (!en || m_ev || !m_run || m_tick) m_psc <= 0; else m_psc <= m_psc + 1;
      if (!en) begin m_cnt <= '0; m_run <= 0; end
      else if (m_ev) begin m_cnt <= '0; m_run <= 1; end
      else if (m_tick) begin
        if (m_cnt != a_mod) m_cnt <= m_cnt + 16'd1;
        else if (cont) m_cnt <= '0;
        else m_run <= 0;
      end
      if (m_hit) m_flag <= 1; else if (fclr) m_flag <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 count vs model", count, m_cnt);
      chk("R7 flag vs model", flag, m_flag);
      chk("R10 ldok vs model", ldok, m_ldok);
      chk("R8 irq vs model", irq, m_flag && ie);
    end
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_sw();
    sw = 1'b1; edges(1); sw = 1'b0;
  endtask

  task automatic load(logic [15:0] md, logic [15:0] dl, logic [2:0] p, logic [1:0] m);
    wmod = md; wdly = dl; wpre = p; wmult = m; mode = 2'd0;
    we = 1'b1; ldset = 1'b1; edges(1); we = 1'b0; ldset = 1'b0;
    edges(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0); chk("R1 ldok", ldok, 0);
    chk("R1 flag", flag, 0);   chk("R1 irq", irq, 0);

    // R2 unselected line ignored, selected line starts count
    en = 1'b1; sel = 4'd3; hw[5] = 1'b1; edges(1); hw[5] = 1'b0;
    edges(3); chk("R2 unselected ignored", count, 0);
    hw[3] = 1'b1; edges(1); hw[3] = 1'b0;
    edges(4); chk("R2 hw line 3 counts", count, 4);
    sel = 4'd15;

    // R3 ratio 1 with software trigger
    trig_sw(); edges(9); chk("R3 ratio1 count", count, 9);

    // R10 set and self-clear, R9 mode 0 transfer
    wmod = 16'd3; wdly = 16'd2; wpre = '0; wmult = '0; mode = 2'd0;
    we = 1'b1; ldset = 1'b1; edges(1); we = 1'b0; ldset = 1'b0;
    chk("R10 ldok set", ldok, 1);
    edges(1); chk("R10 ldok self clear", ldok, 0);

    // R4 continuous wrap, R7 flag
    cont = 1'b1; trig_sw(); edges(6); chk("R4 wrap count", count, 2);
    chk("R7 flag at delay", flag, 1);
    chk("R8 irq masked", irq, 0);
    ie = 1'b1; #1; chk("R8 irq enabled", irq, 1);

    // R5 one-shot hold
    cont = 1'b0; trig_sw(); edges(10); chk("R5 hold at modulus", count, 3);
    fclr = 1'b1; edges(1); fclr = 1'b0;
    chk("R7 flag cleared", flag, 0); chk("R8 irq low", irq, 0);

    // R6 restart while running
    cont = 1'b1; trig_sw(); edges(2); chk("R6 pre-restart", count, 2);
    trig_sw(); chk("R6 restart to zero", count, 0);

    // R9 shadow write without load request
    wmod = 16'd1; we = 1'b1; edges(1); we = 1'b0;
    trig_sw(); edges(3); chk("R9 shadow not active", count, 3);

    // R3 prescaled: pre=1, mult=1 -> 20 cycles per step
    load(16'd100, 16'd50, 3'd1, 2'd1);
    trig_sw(); edges(39); chk("R3 ratio20 before step", count, 1);
    edges(1); chk("R3 ratio20 step", count, 2);

    // R11 disable, R10 set ignored while disabled
    en = 1'b0; edges(1); chk("R11 disabled count", count, 0);
    ldset = 1'b1; edges(1); ldset = 1'b0; chk("R10 set ignored off", ldok, 0);
    edges(3); chk("R11 stays zero", count, 0);

    // random traffic, all modes
    en = 1'b1; load(16'd7, 16'd3, 3'd0, 2'd0);
    for (int i = 0; i < 6000; i++) begin
      en    = ($urandom % 150) != 0;
      if ($urandom % 60 == 0) sel = ($urandom % 2) ? 4'd15 : 4'd2;
      sw    = ($urandom % 45) == 0;
      hw    = ($urandom % 35 == 0) ? 15'(1 << ($urandom % 15)) : 15'd0;
      we    = ($urandom % 20) == 0;
      wmod  = 16'($urandom % 30);
      wdly  = 16'($urandom % 30);
      wpre  = 3'($urandom % 3);
      wmult = 2'($urandom % 2);
      ldset = ($urandom % 25) == 0;
      if ($urandom % 50 == 0) mode = 2'($urandom % 4);
      if ($urandom % 200 == 0) cont = ~cont;
      ie    = ($urandom % 3) != 0;
      fclr  = ($urandom % 15) == 0;
      @(negedge clk);
    end
    sw = 0; hw = '0; we = 0; ldset = 0; fclr = 0;
    edges(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule